// File: doc/BRIEF.md
# Loop termination branch predictor

This block predicts where a counted loop ends. It sits beside instruction fetch. It sees one decoded instruction per cycle, together with the instruction fetched before it. A conditional branch that jumps to a lower address than its own is treated as the closing branch of a loop. The first time such a branch is seen, and the instruction before it was a comparison, the block claims one of a small set of loop slots. The slot records the branch address, the identifiers of the two compared operands, and the terminal value when the comparison uses an immediate.

During the next pass through the loop body the slot is in a learning phase. Every add, subtract, increment or decrement that writes a tracked operand adds its signed amount to that operand's per-iteration step. Operand values are taken from a snoop port when the comparison executes. When the branch is fetched again, learning ends. From then on, each fetch of the branch advances the tracked values by their steps. The prediction is "taken" while the advanced values differ and "not taken" on the iteration where they meet, and that exit releases the slot.

The prediction is combinational with the branch fetch, so the next fetch can use it. A low prediction-valid flag hands the decision to a default predictor.

Top module: `lpred_top`

## Requirements
- R1: A lookup, allocation or prediction happens only when `fetch_opc` is 7 (conditional branch) and `fetch_target` is lower than `fetch_pc`. A forward branch gives `pred_valid`=0 and claims no slot.
- R2: On a backward branch that matches no slot, a slot is claimed when the previously fetched instruction was a comparison (class 1, register against register, or class 2, register against immediate). That fetch, and the next fetch of the same branch, which ends learning, give `pred_valid`=0.
- R3: While a slot is learning, a fetched instruction whose first operand names a tracked operand changes that operand's step. Class 3 adds +1, class 4 adds -1, class 5 adds +imm and class 6 adds -imm. Several such instructions in one pass add up.
- R4: While a slot is learning, a snoop whose register id names a tracked operand loads that operand's current value. Snoops of other registers, and snoops after learning, change nothing.
- R5: On each later fetch of a learned branch, both values advance by their steps. The block gives `pred_valid`=1, with `pred_taken`=1 if the advanced values differ and 0 if they are equal, in the same cycle as the fetch.
- R6: With an immediate comparison, the immediate is the fixed terminal value and takes no step.
- R7: With a register comparison, both operands are tracked and stepped, so a moving terminal value is followed.
- R8: A fetch predicted not taken releases its slot. The next fetch of that branch is a miss.
- R9: A branch whose slot already exists is never learned again. An inner loop keeps predicting while an outer loop's slot is learning, and its instructions do not disturb the outer slot.
- R10: There are 4 slots. A miss picks the lowest free slot. When all slots are in use, it replaces the slot that was claimed earliest.
- R11: Reset (synchronous, active high) frees every slot and clears every learning flag.
- R12: A backward branch that misses, when the previous instruction was not a comparison, claims no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A decoded instruction is present this cycle |
| fetch_pc | input | 16 | Address of the fetched instruction |
| fetch_opc | input | 4 | Opcode class (encodings in R1 to R3) |
| fetch_ra | input | 3 | First operand register id |
| fetch_rb | input | 3 | Second operand register id |
| fetch_imm | input | 16 | Immediate operand |
| fetch_target | input | 16 | Branch target address |
| snoop_valid | input | 1 | Data-bus snoop carries an operand value |
| snoop_reg | input | 3 | Register id of the snooped value |
| snoop_data | input | 16 | Snooped operand value |
| pred_valid | output | 1 | The prediction comes from a learned slot |
| pred_taken | output | 1 | 1: loop continues, 0: loop exits |

## Verification
The assertions assume that a snoop never shares a cycle with a fetch of the learning branch. They also assume that every loop body contains its comparison just before the closing branch, so that a claimed slot always starts from a proper comparison. The stimulus keeps to this. Each loop iteration is sent as modifier fetches, then the comparison, then its snoops (plus one unrelated snoop), then the branch, each in a cycle of its own. Every swept loop runs at least three iterations and ends exactly where the counting values meet.

// File: rtl/lpred_pkg.sv
package lpred_pkg;

    localparam int LP_AW = 16;
    localparam int LP_DW = 16;
    localparam int LP_RW = 3;

    typedef enum logic [3:0] {
        OPC_NOP  = 4'd0,
        OPC_CMP  = 4'd1,
        OPC_CMPI = 4'd2,
        OPC_INC  = 4'd3,
        OPC_DEC  = 4'd4,
        OPC_ADDI = 4'd5,
        OPC_SUBI = 4'd6,
        OPC_BRC  = 4'd7,
        OPC_ALU  = 4'd8
    } opc_e;

    typedef struct packed {
        logic             vld;
        opc_e             opc;
        logic [LP_RW-1:0] ra;
        logic [LP_RW-1:0] rb;
        logic [LP_DW-1:0] imm;
    } insn_t;

    typedef struct packed {
        logic [LP_AW-1:0] pc;
        logic [LP_RW-1:0] id_a;
        logic [LP_RW-1:0] id_b;
        logic             b_imm;
        logic [LP_DW-1:0] term;
    } alloc_t;

    typedef struct packed {
        logic             vld;
        logic             proc;
        logic [LP_AW-1:0] pc;
        logic [LP_RW-1:0] id_a;
        logic [LP_RW-1:0] id_b;
        logic             b_imm;
        logic [LP_DW-1:0] cur_a;
        logic [LP_DW-1:0] cur_b;
        logic [LP_DW-1:0] step_a;
        logic [LP_DW-1:0] step_b;
    } entry_t;

    function automatic logic is_modifier(opc_e op);
        return (op == OPC_INC) || (op == OPC_DEC) ||
               (op == OPC_ADDI) || (op == OPC_SUBI);
    endfunction

    function automatic logic is_compare(opc_e op);
        return (op == OPC_CMP) || (op == OPC_CMPI);
    endfunction

    // Signed per-iteration amount, two's complement modulo 2^LP_DW.
    function automatic logic [LP_DW-1:0] step_of(opc_e op, logic [LP_DW-1:0] imm);
        logic [LP_DW-1:0] r;
        case (op)
            OPC_INC:  r = LP_DW'(1);
            OPC_DEC:  r = '1;
            OPC_ADDI: r = imm;
            OPC_SUBI: r = (~imm) + LP_DW'(1);
            default:  r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lpred_prev.sv
module lpred_prev
    import lpred_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  insn_t cur_i,
    output insn_t prev_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_o <= '0;
        end else if (cur_i.vld) begin
            prev_o <= cur_i;
        end
    end

endmodule

// File: rtl/lpred_entry.sv
module lpred_entry
    import lpred_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LP_AW-1:0] look_pc,
    input  logic             alloc_en,
    input  alloc_t           alloc_d,
    input  logic             fire,
    input  logic             mod_en,
    input  logic [LP_RW-1:0] mod_reg,
    input  logic [LP_DW-1:0] mod_step,
    input  logic             snoop_en,
    input  logic [LP_RW-1:0] snoop_reg,
    input  logic [LP_DW-1:0] snoop_data,
    output logic             valid_o,
    output logic             proc_o,
    output logic             hit_o,
    output logic             exit_o
);

    entry_t           st;
    logic [LP_DW-1:0] next_a;
    logic [LP_DW-1:0] next_b;
    logic             trk_b;

    assign next_a  = st.cur_a + st.step_a;
    assign next_b  = st.cur_b + st.step_b;
    assign trk_b   = !st.b_imm;
    assign valid_o = st.vld;
    assign proc_o  = st.proc;
    assign hit_o   = st.vld && (st.pc == look_pc);
    assign exit_o  = (next_a == next_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (alloc_en) begin
            st.vld    <= 1'b1;
            st.proc   <= 1'b1;
            st.pc     <= alloc_d.pc;
            st.id_a   <= alloc_d.id_a;
            st.id_b   <= alloc_d.id_b;
            st.b_imm  <= alloc_d.b_imm;
            st.cur_a  <= '0;
            st.cur_b  <= alloc_d.b_imm ? alloc_d.term : '0;
            st.step_a <= '0;
            st.step_b <= '0;
        end else if (st.vld) begin
            if (fire) begin
                if (st.proc) begin
                    st.proc <= 1'b0;
                end else begin
                    st.cur_a <= next_a;
                    st.cur_b <= next_b;
                    if (exit_o) begin
                        st.vld <= 1'b0;
                    end
                end
            end else if (st.proc) begin
                if (mod_en && (mod_reg == st.id_a)) begin
                    st.step_a <= st.step_a + mod_step;
                end
                if (mod_en && trk_b && (mod_reg == st.id_b)) begin
                    st.step_b <= st.step_b + mod_step;
                end
                if (snoop_en && (snoop_reg == st.id_a)) begin
                    st.cur_a <= snoop_data;
                end
                if (snoop_en && trk_b && (snoop_reg == st.id_b)) begin
                    st.cur_b <= snoop_data;
                end
            end
        end
    end

endmodule

// File: rtl/lpred_victim.sv
module lpred_victim #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] valid_vec,
    input  logic         alloc_go,
    output logic [N-1:0] victim_oh
);

    // older[i][j] set: slot i was claimed before slot j
    logic [N-1:0] older [N];
    logic [N-1:0] free_oh;
    logic [N-1:0] oldest_oh;

    always_comb begin
        free_oh = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_oh    = '0;
                free_oh[i] = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_oldest
        localparam logic [N-1:0] SELF = N'(1) << g;
        assign oldest_oh[g] = &(older[g] | SELF);
    end

    assign victim_oh = (|free_oh) ? free_oh : oldest_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    older[i][j] <= 1'(i < j);
                end
            end
        end else if (alloc_go) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (victim_oh[i]) begin
                        older[i][j] <= 1'b0;
                    end else if (victim_oh[j] && (i != j)) begin
                        older[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lpred_top.sv
module lpred_top
    import lpred_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [LP_AW-1:0] fetch_pc,
    input  logic [3:0]       fetch_opc,
    input  logic [LP_RW-1:0] fetch_ra,
    input  logic [LP_RW-1:0] fetch_rb,
    input  logic [LP_DW-1:0] fetch_imm,
    input  logic [LP_AW-1:0] fetch_target,
    input  logic             snoop_valid,
    input  logic [LP_RW-1:0] snoop_reg,
    input  logic [LP_DW-1:0] snoop_data,
    output logic             pred_valid,
    output logic             pred_taken
);

    localparam int N = NUM_ENTRIES;

    insn_t            cur_insn;
    insn_t            prev_insn;
    alloc_t           alloc_d;
    opc_e             opc;
    logic             br_fetch;
    logic             any_hit;
    logic             alloc_go;
    logic             mod_en;
    logic [LP_DW-1:0] mod_step;
    logic             sel_proc;
    logic             sel_exit;
    logic [N-1:0]     ent_valid;
    logic [N-1:0]     ent_proc;
    logic [N-1:0]     ent_hit;
    logic [N-1:0]     ent_exit;
    logic [N-1:0]     hit_vec;
    logic [N-1:0]     victim_oh;
    logic [N-1:0]     alloc_vec;

    assign opc      = opc_e'(fetch_opc);
    assign cur_insn = '{vld: fetch_valid, opc: opc, ra: fetch_ra,
                        rb: fetch_rb, imm: fetch_imm};

    lpred_prev i_prev (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (cur_insn),
        .prev_o (prev_insn)
    );

    assign br_fetch = fetch_valid && (opc == OPC_BRC) && (fetch_target < fetch_pc);
    assign hit_vec  = ent_hit & {N{br_fetch}};
    assign any_hit  = |hit_vec;
    assign alloc_go = br_fetch && !any_hit && prev_insn.vld && is_compare(prev_insn.opc);
    assign alloc_vec = victim_oh & {N{alloc_go}};
    assign mod_en   = fetch_valid && is_modifier(opc);
    assign mod_step = step_of(opc, fetch_imm);

    assign alloc_d = '{pc: fetch_pc, id_a: prev_insn.ra, id_b: prev_insn.rb,
                       b_imm: (prev_insn.opc == OPC_CMPI), term: prev_insn.imm};

    lpred_victim #(.N(N)) i_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (ent_valid),
        .alloc_go  (alloc_go),
        .victim_oh (victim_oh)
    );

    for (genvar g = 0; g < N; g++) begin : g_ent
        lpred_entry i_entry (
            .clk        (clk),
            .rst        (rst),
            .look_pc    (fetch_pc),
            .alloc_en   (alloc_vec[g]),
            .alloc_d    (alloc_d),
            .fire       (hit_vec[g]),
            .mod_en     (mod_en),
            .mod_reg    (fetch_ra),
            .mod_step   (mod_step),
            .snoop_en   (snoop_valid),
            .snoop_reg  (snoop_reg),
            .snoop_data (snoop_data),
            .valid_o    (ent_valid[g]),
            .proc_o     (ent_proc[g]),
            .hit_o      (ent_hit[g]),
            .exit_o     (ent_exit[g])
        );
    end

    always_comb begin
        sel_proc = 1'b0;
        sel_exit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                sel_proc = sel_proc | ent_proc[i];
                sel_exit = sel_exit | ent_exit[i];
            end
        end
    end

    assign pred_valid = any_hit && !sel_proc;
    assign pred_taken = pred_valid && !sel_exit;

endmodule

// File: rtl/lpred_chk.sv
module lpred_chk
    import lpred_pkg::*;
#(
    parameter int N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_valid,
    input logic [3:0]       fetch_opc,
    input logic [LP_AW-1:0] fetch_pc,
    input logic [LP_AW-1:0] fetch_target,
    input logic             pred_valid,
    input logic             pred_taken,
    input logic [N-1:0]     valid_vec,
    input logic [N-1:0]     proc_vec,
    input logic [N-1:0]     hit_vec,
    input logic             alloc_go
);

    // R1
    backward_only_chk: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> (fetch_valid && (fetch_opc == 4'd7) && (fetch_target < fetch_pc)));

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R2
    learning_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (|(hit_vec & proc_vec)) |-> !pred_valid);

    // R2
    miss_silent_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_go |-> !pred_valid);

    // R8
    exit_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !pred_taken) |=>
            ($countones(valid_vec) + 1 == $countones($past(valid_vec))));

    // R10
    full_replace_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_go && (&valid_vec)) |=> (&valid_vec));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));

endmodule

bind lpred_top lpred_chk #(.N(NUM_ENTRIES)) i_lpred_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_opc    (fetch_opc),
    .fetch_pc     (fetch_pc),
    .fetch_target (fetch_target),
    .pred_valid   (pred_valid),
    .pred_taken   (pred_taken),
    .valid_vec    (ent_valid),
    .proc_vec     (ent_proc),
    .hit_vec      (hit_vec),
    .alloc_go     (alloc_go)
);

// File: tb/test_lpred_top.sv
module test_lpred_top;
    import lpred_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic [3:0]  fetch_opc = '0;
    logic [2:0]  fetch_ra = '0;
    logic [2:0]  fetch_rb = '0;
    logic [15:0] fetch_imm = '0;
    logic [15:0] fetch_target = '0;
    logic        snoop_valid = 1'b0;
    logic [2:0]  snoop_reg = '0;
    logic [15:0] snoop_data = '0;
    logic        pred_valid;
    logic        pred_taken;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpred_top i_lpred_top (
        .clk          (clk),
        .rst          (rst),
        .fetch_valid  (fetch_valid),
        .fetch_pc     (fetch_pc),
        .fetch_opc    (fetch_opc),
        .fetch_ra     (fetch_ra),
        .fetch_rb     (fetch_rb),
        .fetch_imm    (fetch_imm),
        .fetch_target (fetch_target),
        .snoop_valid  (snoop_valid),
        .snoop_reg    (snoop_reg),
        .snoop_data   (snoop_data),
        .pred_valid   (pred_valid),
        .pred_taken   (pred_taken)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_fetch(int pc, opc_e op, int ra, int rb, int imm, int tgt,
                            output bit pv, output bit pt);
        @(negedge clk);
        fetch_valid  = 1'b1;
        fetch_pc     = 16'(pc);
        fetch_opc    = op;
        fetch_ra     = 3'(ra);
        fetch_rb     = 3'(rb);
        fetch_imm    = 16'(imm);
        fetch_target = 16'(tgt);
        #1;
        pv = pred_valid;
        pt = pred_taken;
        @(posedge clk);
        #1;
        fetch_valid = 1'b0;
    endtask

    task automatic fetch_n(int pc, opc_e op, int ra, int rb, int imm);
        bit pv, pt;
        do_fetch(pc, op, ra, rb, imm, 0, pv, pt);
    endtask

    task automatic snoop(int r, int v);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_reg   = 3'(r);
        snoop_data  = 16'(v);
        @(posedge clk);
        #1;
        snoop_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int apply(opc_e op, int v, int imm);
        int r;
        case (op)
            OPC_INC:  r = v + 1;
            OPC_DEC:  r = v - 1;
            OPC_ADDI: r = v + imm;
            OPC_SUBI: r = v - imm;
            default:  r = v;
        endcase
        return r & 16'hffff;
    endfunction

    // Body: up to two modifiers of a, one of b, compare, branch back to pc0.
    task automatic loop_run(string tag, int pc0, bit reg_mode, int ra, int rb,
                            int a0, int b0, opc_e m1, int i1, opc_e m2, int i2,
                            opc_e mb, int ib);
        int va = a0 & 16'hffff;
        int vb = b0 & 16'hffff;
        bit pv, pt;
        bit done = 1'b0;
        for (int it = 1; it <= 64 && !done; it++) begin
            if (m1 != OPC_NOP) begin
                fetch_n(pc0, m1, ra, 0, i1);
                va = apply(m1, va, i1);
            end
            if (m2 != OPC_NOP) begin
                fetch_n(pc0 + 1, m2, ra, 0, i2);
                va = apply(m2, va, i2);
            end
            if (reg_mode && mb != OPC_NOP) begin
                fetch_n(pc0 + 2, mb, rb, 0, ib);
                vb = apply(mb, vb, ib);
            end
            fetch_n(pc0 + 3, reg_mode ? OPC_CMP : OPC_CMPI, ra, rb, reg_mode ? 0 : b0);
            snoop(ra, va);
            if (reg_mode) snoop(rb, vb);
            snoop(7, 16'h5a5a);   // R4: unrelated register, must be ignored
            do_fetch(pc0 + 4, OPC_BRC, 0, 0, 0, pc0, pv, pt);
            if (it <= 2) begin
                check({tag, " R2 no prediction while claiming/learning"}, pv, 0);
            end else begin
                check({tag, " R5 prediction valid"}, pv, 1);
                check({tag, " R5 taken"}, pt, (va != vb) ? 1 : 0);
            end
            if (va == vb) done = 1'b1;
        end
        check({tag, " loop ended"}, done, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        bit pv, pt;
        int pcb;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: nothing held after reset
        fetch_n(16'h0f, OPC_CMPI, 1, 0, 9);
        do_fetch(16'h10, OPC_BRC, 0, 0, 0, 16'h08, pv, pt);
        check("R11 empty after reset", pv, 0);
        fetch_n(16'h20, OPC_NOP, 0, 0, 0);

        // R3 R5 R6: up-counting against an immediate terminal value
        pcb = 16'h100;
        for (int s = 1; s <= 3; s++) begin
            for (int t = 3; t <= 7; t++) begin
                if (s == 1)
                    loop_run("R3 R6 up", pcb, 1'b0, 1, 0, 10, 10 + t,
                             OPC_INC, 0, OPC_NOP, 0, OPC_NOP, 0);
                else
                    loop_run("R3 R6 up-sum", pcb, 1'b0, 1, 0, 10, 10 + s * t,
                             OPC_INC, 0, OPC_ADDI, s - 1, OPC_NOP, 0);
                pcb += 16;
            end
        end

        // R3 R6: down-counting
        for (int s = 1; s <= 3; s++) begin
            for (int t = 3; t <= 7; t++) begin
                if (s == 1)
                    loop_run("R3 R6 down", pcb, 1'b0, 2, 0, 60, 60 - t,
                             OPC_DEC, 0, OPC_NOP, 0, OPC_NOP, 0);
                else
                    loop_run("R3 R6 down-sub", pcb, 1'b0, 2, 0, 60, 60 - s * t,
                             OPC_SUBI, s, OPC_NOP, 0, OPC_NOP, 0);
                pcb += 16;
            end
        end

        // R7: both operands moving
        for (int t = 3; t <= 7; t++) begin
            loop_run("R7 converge", pcb, 1'b1, 3, 4, 0, 2 * t,
                     OPC_INC, 0, OPC_NOP, 0, OPC_DEC, 0);
            pcb += 16;
            loop_run("R7 chase", pcb, 1'b1, 3, 4, 0, t,
                     OPC_ADDI, 2, OPC_NOP, 0, OPC_ADDI, 1);
            pcb += 16;
        end

        // R8: after exit the same branch misses again
        loop_run("R8 first run", 16'h700, 1'b0, 1, 0, 0, 3,
                 OPC_INC, 0, OPC_NOP, 0, OPC_NOP, 0);
        fetch_n(16'h703, OPC_CMPI, 1, 0, 3);
        do_fetch(16'h704, OPC_BRC, 0, 0, 0, 16'h700, pv, pt);
        check("R8 released slot misses", pv, 0);

        // R12: previous instruction not a comparison claims nothing
        fetch_n(16'h7fe, OPC_NOP, 0, 0, 0);
        do_fetch(16'h800, OPC_BRC, 0, 0, 0, 16'h7f0, pv, pt);
        check("R12 miss without compare", pv, 0);
        fetch_n(16'h7ff, OPC_CMPI, 4, 0, 100);
        do_fetch(16'h800, OPC_BRC, 0, 0, 0, 16'h7f0, pv, pt);
        check("R12 claim after compare", pv, 0);
        fetch_n(16'h7f0, OPC_INC, 4, 0, 0);
        fetch_n(16'h7ff, OPC_CMPI, 4, 0, 100);
        snoop(4, 2);
        do_fetch(16'h800, OPC_BRC, 0, 0, 0, 16'h7f0, pv, pt);
        check("R12 learning end", pv, 0);
        fetch_n(16'h7f0, OPC_INC, 4, 0, 0);
        fetch_n(16'h7ff, OPC_CMPI, 4, 0, 100);
        do_fetch(16'h800, OPC_BRC, 0, 0, 0, 16'h7f0, pv, pt);
        check("R12 predicting", pv, 1);
        check("R12 taken", pt, 1);

        // R1: forward branch claims nothing
        fetch_n(16'h8ff, OPC_CMPI, 5, 0, 100);
        do_fetch(16'h900, OPC_BRC, 0, 0, 0, 16'h950, pv, pt);
        check("R1 forward branch", pv, 0);
        fetch_n(16'h8ff, OPC_CMPI, 5, 0, 100);
        do_fetch(16'h900, OPC_BRC, 0, 0, 0, 16'h8f0, pv, pt);
        check("R1 backward claim", pv, 0);
        fetch_n(16'h8f0, OPC_INC, 5, 0, 0);
        fetch_n(16'h8ff, OPC_CMPI, 5, 0, 100);
        snoop(5, 2);
        do_fetch(16'h900, OPC_BRC, 0, 0, 0, 16'h8f0, pv, pt);
        check("R1 learning end", pv, 0);
        fetch_n(16'h8f0, OPC_INC, 5, 0, 0);
        do_fetch(16'h900, OPC_BRC, 0, 0, 0, 16'h8f0, pv, pt);
        check("R1 predicting", pv, 1);

        // R11: reset in mid-run frees the slot
        pulse_reset();
        fetch_n(16'h8f0, OPC_CMPI, 5, 0, 100);
        do_fetch(16'h900, OPC_BRC, 0, 0, 0, 16'h8f0, pv, pt);
        check("R11 mid-run reset", pv, 0);

        // R9: inner loop inside an outer loop that is learning
        pulse_reset();
        begin
            int v5 = 0;
            for (int k = 1; k <= 4; k++) begin
                loop_run("R9 inner", 16'h200, 1'b0, 6, 0, 0, 3,
                         OPC_INC, 0, OPC_NOP, 0, OPC_NOP, 0);
                fetch_n(16'h210, OPC_INC, 5, 0, 0);
                v5++;
                fetch_n(16'h211, OPC_CMPI, 5, 0, 4);
                snoop(5, v5);
                do_fetch(16'h212, OPC_BRC, 0, 0, 0, 16'h1f0, pv, pt);
                if (k <= 2) begin
                    check("R9 outer learning", pv, 0);
                end else begin
                    check("R9 outer valid", pv, 1);
                    check("R9 outer taken", pt, (v5 != 4) ? 1 : 0);
                end
            end
        end

        // R10: four slots, earliest-claimed replaced
        pulse_reset();
        for (int i = 0; i < 4; i++) begin
            fetch_n(16'h3ff + 16 * i, OPC_CMPI, i, 0, 100);
            do_fetch(16'h400 + 16 * i, OPC_BRC, 0, 0, 0, 16'h3f0 + 16 * i, pv, pt);
            fetch_n(16'h3f0 + 16 * i, OPC_INC, i, 0, 0);
            fetch_n(16'h3ff + 16 * i, OPC_CMPI, i, 0, 100);
            snoop(i, 2);
            do_fetch(16'h400 + 16 * i, OPC_BRC, 0, 0, 0, 16'h3f0 + 16 * i, pv, pt);
        end
        for (int i = 0; i < 4; i++) begin
            do_fetch(16'h400 + 16 * i, OPC_BRC, 0, 0, 0, 16'h3f0 + 16 * i, pv, pt);
            check("R10 slot held", pv, 1);
        end
        fetch_n(16'h43f, OPC_CMPI, 4, 0, 100);
        do_fetch(16'h440, OPC_BRC, 0, 0, 0, 16'h430, pv, pt);
        check("R10 fifth loop miss", pv, 0);
        for (int i = 1; i < 4; i++) begin
            do_fetch(16'h400 + 16 * i, OPC_BRC, 0, 0, 0, 16'h3f0 + 16 * i, pv, pt);
            check("R10 younger slot kept", pv, 1);
        end
        fetch_n(16'h3ff, OPC_CMPI, 0, 0, 100);
        do_fetch(16'h400, OPC_BRC, 0, 0, 0, 16'h3f0, pv, pt);
        check("R10 oldest evicted", pv, 0);
        do_fetch(16'h420, OPC_BRC, 0, 0, 0, 16'h410, pv, pt);
        check("R10 slot kept after second eviction", pv, 1);
        fetch_n(16'h40f, OPC_CMPI, 1, 0, 100);
        do_fetch(16'h410, OPC_BRC, 0, 0, 0, 16'h400, pv, pt);
        check("R10 next oldest evicted", pv, 0);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule